// File: doc/BRIEF.md
# Critical Temperature Limit Monitor

This block watches finished temperature conversions on two channels, a local one and a remote one. Each channel is compared with its own programmable critical limit. The block drives an active-low critical output and keeps one critical status flag per channel. A channel enters its critical state when a finished result is above its limit. It leaves that state only when a later result falls below the limit minus a shared hysteresis value. The hysteresis value comes from its own input, not from the limit.

A mode input selects how the flags behave. In interrupt mode, a status read clears the flags. A flag then sets again at each later conversion end while its channel is still critical. In comparator mode, a status read leaves the flags alone, and each flag follows its channel's critical state at every conversion end. The critical output cannot be masked. A status read also produces a one-cycle request to set the general alert mask bit, but only when some status flag that counts for that purpose is set.

Top module: `crit_temp_monitor`

## Requirements
- R1: While reset is active and after it is released, `crit_n` is 1, both critical flags are 0 and `mask_set` is 0.
- R2: One cycle after `conv_done` with a channel's result strictly greater than that channel's limit, `crit_n` is 0 and that channel's flag is 1. A result equal to the limit does not trigger this.
- R3: A critical channel leaves its critical state only at a `conv_done` whose result is strictly below limit minus hysteresis. A result equal to that threshold, or between the threshold and the limit, keeps the channel critical.
- R4: `crit_n` is 0 exactly when at least one channel is critical. It changes only in the cycle after a `conv_done`.
- R5: Each channel uses only its own temperature and limit. An over-limit remote result sets only the remote flag.
- R6: In interrupt mode (`mode_comp` = 0), `stat_rd` clears both critical flags on the next cycle. A result below the release threshold does not clear a flag. A `conv_done` that leaves a channel critical sets its flag, and this set wins over a read in the same cycle.
- R7: In comparator mode (`mode_comp` = 1), `stat_rd` has no effect on the flags. After each `conv_done`, each flag equals its channel's critical state.
- R8: `stat_rd` has no effect on `crit_n`, and no input masks `crit_n`.
- R9: `mask_set` is 1 for one cycle after a `stat_rd` cycle only if, in that read cycle, the local flag, the remote flag or any bit of `other_flags` is 1. `adc_busy` and `diode_fault` are ignored for this decision.
- R10: All values are signed two's complement of width TW. The release threshold limit minus hysteresis saturates to the most negative or the most positive value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: conversion results are valid |
| local_temp | input | TW | Signed local result |
| remote_temp | input | TW | Signed remote result |
| local_limit | input | TW | Signed local critical limit |
| remote_limit | input | TW | Signed remote critical limit |
| hyst | input | TW | Signed shared hysteresis |
| mode_comp | input | 1 | 0 = interrupt mode, 1 = comparator mode |
| stat_rd | input | 1 | One-cycle strobe: the status register is read |
| other_flags | input | NOTH | Other status flags that count for the mask request |
| adc_busy | input | 1 | Converter-busy flag, excluded from the mask request |
| diode_fault | input | 1 | Remote-sensor fault flag, excluded from the mask request |
| crit_n | output | 1 | Critical output, active low |
| local_flag | output | 1 | Local critical status flag |
| remote_flag | output | 1 | Remote critical status flag |
| mask_set | output | 1 | One-cycle request to set the general alert mask bit |

## Verification
A wrong channel critical state shows on `crit_n` one cycle after the `conv_done` that should have changed it. It also shows on the channel's flag at that conversion end, or at the next one if the bad state only affects a later result. A flag cleared or kept by mistake shows on its own output one cycle after the read or the conversion. In the next read cycle it also shows on `mask_set`. A wrong saturated release threshold only shows at a conversion whose result lies between the wrapped threshold and the correct one, so the saturation case is driven with results at the most negative value.

// File: rtl/crit_mon_pkg.sv
package crit_mon_pkg;

    localparam int NCH = 2;
    localparam int CH_LOCAL  = 0;
    localparam int CH_REMOTE = 1;

    typedef struct packed {
        logic [NCH-1:0] crit;
        logic [NCH-1:0] flag;
        logic           mask_set;
    } mon_state_t;

endpackage

// File: rtl/crit_release_calc.sv
module crit_release_calc #(
    parameter int TW = 12
) (
    input  logic signed [TW-1:0] limit,
    input  logic signed [TW-1:0] hyst,
    output logic signed [TW-1:0] release_thr
);
    localparam logic signed [TW-1:0] SMIN = {1'b1, {(TW-1){1'b0}}};
    localparam logic signed [TW-1:0] SMAX = {1'b0, {(TW-1){1'b1}}};

    logic signed [TW:0] diff;

    always_comb begin
        diff = {limit[TW-1], limit} - {hyst[TW-1], hyst};
        if (diff[TW] != diff[TW-1]) begin
            release_thr = diff[TW] ? SMIN : SMAX;
        end else begin
            release_thr = diff[TW-1:0];
        end
    end
endmodule

// File: rtl/crit_chan_cmp.sv
module crit_chan_cmp #(
    parameter int TW = 12
) (
    input  logic signed [TW-1:0] temp,
    input  logic signed [TW-1:0] limit,
    input  logic signed [TW-1:0] hyst,
    output logic                 over,
    output logic                 under
);
    logic signed [TW-1:0] rel_thr;

    crit_release_calc #(.TW(TW)) rel_i (
        .limit       (limit),
        .hyst        (hyst),
        .release_thr (rel_thr)
    );

    assign over  = temp > limit;
    assign under = temp < rel_thr;
endmodule

// File: rtl/crit_temp_monitor.sv
module crit_temp_monitor
    import crit_mon_pkg::*;
#(
    parameter int TW   = 12,
    parameter int NOTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 conv_done,
    input  logic signed [TW-1:0] local_temp,
    input  logic signed [TW-1:0] remote_temp,
    input  logic signed [TW-1:0] local_limit,
    input  logic signed [TW-1:0] remote_limit,
    input  logic signed [TW-1:0] hyst,
    input  logic                 mode_comp,
    input  logic                 stat_rd,
    input  logic [NOTH-1:0]      other_flags,
    input  logic                 adc_busy,
    input  logic                 diode_fault,
    output logic                 crit_n,
    output logic                 local_flag,
    output logic                 remote_flag,
    output logic                 mask_set
);
    logic signed [TW-1:0] temp_a  [NCH];
    logic signed [TW-1:0] limit_a [NCH];
    logic [NCH-1:0]       over_v;
    logic [NCH-1:0]       under_v;

    mon_state_t st_d, st_q;

    assign temp_a[CH_LOCAL]   = local_temp;
    assign temp_a[CH_REMOTE]  = remote_temp;
    assign limit_a[CH_LOCAL]  = local_limit;
    assign limit_a[CH_REMOTE] = remote_limit;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        crit_chan_cmp #(.TW(TW)) cmp_i (
            .temp  (temp_a[c]),
            .limit (limit_a[c]),
            .hyst  (hyst),
            .over  (over_v[c]),
            .under (under_v[c])
        );
    end

    // busy and fault flags deliberately take no part in the mask request
    logic excluded_unused;
    assign excluded_unused = adc_busy ^ diode_fault;

    always_comb begin
        logic crit_nx;
        st_d = st_q;
        st_d.mask_set = stat_rd && ((|st_q.flag) || (|other_flags));
        for (int c = 0; c < NCH; c++) begin
            crit_nx = st_q.crit[c];
            if (conv_done) begin
                if (over_v[c]) begin
                    crit_nx = 1'b1;
                end else if (under_v[c]) begin
                    crit_nx = 1'b0;
                end
            end
            st_d.crit[c] = crit_nx;
            if (mode_comp) begin
                if (conv_done) begin
                    st_d.flag[c] = crit_nx;
                end
            end else begin
                if (stat_rd) begin
                    st_d.flag[c] = 1'b0;
                end
                if (conv_done && crit_nx) begin
                    st_d.flag[c] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crit_n      = ~(|st_q.crit);
    assign local_flag  = st_q.flag[CH_LOCAL];
    assign remote_flag = st_q.flag[CH_REMOTE];
    assign mask_set    = st_q.mask_set;
endmodule

// File: rtl/crit_temp_monitor_chk.sv
module crit_temp_monitor_chk #(
    parameter int TW   = 12,
    parameter int NOTH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 conv_done,
    input logic signed [TW-1:0] local_temp,
    input logic signed [TW-1:0] remote_temp,
    input logic signed [TW-1:0] local_limit,
    input logic signed [TW-1:0] remote_limit,
    input logic                 mode_comp,
    input logic                 stat_rd,
    input logic                 crit_n,
    input logic                 local_flag,
    input logic                 remote_flag,
    input logic                 mask_set
);
    p_pin_only_at_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(crit_n));

    p_local_over_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && (local_temp > local_limit) |=> !crit_n && local_flag);

    p_remote_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && (remote_temp > remote_limit) |=> !crit_n && remote_flag);

    p_intr_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_comp && stat_rd && !conv_done |=> !local_flag && !remote_flag);

    p_comp_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_comp && !conv_done |=> $stable(local_flag) && $stable(remote_flag));

    p_read_keeps_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !conv_done |=> $stable(crit_n));

    p_mask_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> !mask_set);
endmodule

bind crit_temp_monitor crit_temp_monitor_chk #(.TW(TW), .NOTH(NOTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_done    (conv_done),
    .local_temp   (local_temp),
    .remote_temp  (remote_temp),
    .local_limit  (local_limit),
    .remote_limit (remote_limit),
    .mode_comp    (mode_comp),
    .stat_rd      (stat_rd),
    .crit_n       (crit_n),
    .local_flag   (local_flag),
    .remote_flag  (remote_flag),
    .mask_set     (mask_set)
);

// File: tb/crit_temp_monitor_tb_top.sv
module crit_temp_monitor_tb_top;
    localparam int TW       = 12;
    localparam int NOTH     = 2;
    localparam time CLK_PER = 10ns;

    typedef struct packed {
        logic [23:0]   tag;
        logic          conv;
        logic [TW-1:0] lt;
        logic [TW-1:0] rt;
        logic          mode;
        logic          rd;
        logic          oth;
        logic          busy;
        logic          flt;
        logic [3:0]    exp; // {crit_n, local_flag, remote_flag, mask_set}
    } vec_t;

    localparam int NV = 20;
    // limits local 100, remote 80, hysteresis 10: release 90 / 70
    localparam vec_t VEC [NV] = '{
        '{"R2 ", 1'b1, 12'd50,  12'd50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000},
        '{"R2 ", 1'b1, 12'd100, 12'd50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000},
        '{"R2 ", 1'b1, 12'd101, 12'd50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100},
        '{"R8 ", 1'b0, 12'd101, 12'd50, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001},
        '{"R6 ", 1'b1, 12'd95,  12'd50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100},
        '{"R9 ", 1'b0, 12'd95,  12'd50, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001},
        '{"R3 ", 1'b1, 12'd90,  12'd50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100},
        '{"R6 ", 1'b1, 12'd89,  12'd50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1100},
        '{"R6 ", 1'b0, 12'd89,  12'd50, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1001},
        '{"R9 ", 1'b0, 12'd89,  12'd50, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b1000},
        '{"R9 ", 1'b0, 12'd89,  12'd50, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1001},
        '{"R5 ", 1'b1, 12'd50,  12'd81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010},
        '{"R4 ", 1'b0, 12'd200, 12'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010},
        '{"R6 ", 1'b1, 12'd50,  12'd75, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0011},
        '{"R7 ", 1'b0, 12'd50,  12'd75, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0011},
        '{"R7 ", 1'b1, 12'd50,  12'd72, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010},
        '{"R7 ", 1'b1, 12'd50,  12'd69, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000},
        '{"R5 ", 1'b1, 12'd120, 12'd90, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110},
        '{"R4 ", 1'b1, 12'd89,  12'd90, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010},
        '{"R7 ", 1'b1, 12'd89,  12'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 conv_done = 1'b0;
    logic signed [TW-1:0] local_temp = '0;
    logic signed [TW-1:0] remote_temp = '0;
    logic signed [TW-1:0] local_limit = 12'sd100;
    logic signed [TW-1:0] remote_limit = 12'sd80;
    logic signed [TW-1:0] hyst = 12'sd10;
    logic                 mode_comp = 1'b0;
    logic                 stat_rd = 1'b0;
    logic [NOTH-1:0]      other_flags = '0;
    logic                 adc_busy = 1'b0;
    logic                 diode_fault = 1'b0;
    logic                 crit_n, local_flag, remote_flag, mask_set;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    crit_temp_monitor #(.TW(TW), .NOTH(NOTH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_done    (conv_done),
        .local_temp   (local_temp),
        .remote_temp  (remote_temp),
        .local_limit  (local_limit),
        .remote_limit (remote_limit),
        .hyst         (hyst),
        .mode_comp    (mode_comp),
        .stat_rd      (stat_rd),
        .other_flags  (other_flags),
        .adc_busy     (adc_busy),
        .diode_fault  (diode_fault),
        .crit_n       (crit_n),
        .local_flag   (local_flag),
        .remote_flag  (remote_flag),
        .mask_set     (mask_set)
    );

    task automatic check(string req, logic [3:0] exp);
        logic [3:0] act;
        act = {crit_n, local_flag, remote_flag, mask_set};
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: {crit_n,lflag,rflag,mask} actual %b expected %b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // one conversion on the local channel, result checked after the next edge
    task automatic local_conv(logic signed [TW-1:0] t, string req, logic [3:0] exp);
        conv_done  = 1'b1;
        local_temp = t;
        @(negedge clk);
        conv_done = 1'b0;
        check(req, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        // R1: reset state, during and after reset
        @(negedge clk);
        check("R1", 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 4'b1000);

        for (int i = 0; i < NV; i++) begin
            conv_done   = VEC[i].conv;
            local_temp  = VEC[i].lt;
            remote_temp = VEC[i].rt;
            mode_comp   = VEC[i].mode;
            stat_rd     = VEC[i].rd;
            other_flags = {1'b0, VEC[i].oth};
            adc_busy    = VEC[i].busy;
            diode_fault = VEC[i].flt;
            @(negedge clk);
            check(string'(VEC[i].tag), VEC[i].exp);
        end
        conv_done = 1'b0; stat_rd = 1'b0; other_flags = '0;
        adc_busy = 1'b0; diode_fault = 1'b0; mode_comp = 1'b0;
        remote_temp = 12'sd0;

        // R1: reset from a critical state
        local_conv(12'sd120, "R2", 4'b0100);
        rst_n = 1'b0;
        #1;
        check("R1", 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 4'b1000);

        // R10: release threshold -2040-100 saturates to -2048
        local_limit = -12'sd2040;
        hyst        = 12'sd100;
        local_conv(-12'sd2030, "R10", 4'b0100);
        local_conv(-12'sd2048, "R10", 4'b0100);
        // R3 R10: with zero hysteresis -2048 is below the release point
        hyst = 12'sd0;
        local_conv(-12'sd2048, "R3", 4'b1100);

        // R10: 2040-(-100) saturates to 2047; 2047 holds the critical state
        local_limit = 12'sd2040;
        hyst        = -12'sd100;
        local_conv(12'sd2047, "R10", 4'b0100);
        local_conv(12'sd2047, "R10", 4'b0100);

        summary();
    end
endmodule